// File: doc/BRIEF.md
# Six-Channel Two-Stage Delay-and-Sum Beamformer

This block combines six streams of echo samples, one per transducer ring, into a single beam. All streams share one sample clock. Each channel is delayed by a programmable amount, and the six delayed signals are added to give one beam sample per clock. The delay of a channel has two parts. The whole-sample part selects a tap of a shift-register delay line. The sub-sample part, counted in eighths of a sample, drives a four-tap interpolating filter. That filter forms its products from small tables of coefficient multiples. It does not use general multipliers.

Software writes delay words into a staging bank, one channel at a time. An `apply` strobe, issued between acquisitions, does three things in one edge: it copies the staging bank into the working delays, it rebuilds the product tables, and it empties every delay line and pipeline register. A small controller marks the beam as valid once every tap of every channel holds a sample taken after that strobe.

The controller has three states. `S_IDLE` is entered from reset, and nothing is valid there. `S_FILL` counts cycles after a strobe. `S_RUN` marks the beam valid. The transitions are:
- `S_IDLE` goes to `S_FILL` on `apply`.
- `S_FILL` goes back to `S_FILL` on `apply`, which restarts the count.
- `S_FILL` goes to `S_RUN` when the count reaches its limit.
- `S_RUN` goes to `S_FILL` on `apply`.

Top module: `bf_beamformer`

## Requirements
- R1: Six channels of 8-bit two's complement samples are taken every clock. Channel c occupies bits [8c+7:8c] of `smp_in`. One beam sample is produced every clock.
- R2: The whole-sample delay I is 0 to 63 clocks. A sample presented at the edge after acquisition step n reaches the filter taps I cycles later than it would with I = 0.
- R3: The fraction f (0..7, in eighths) selects four coefficients h_f[t] = round(256 · L_t(1 + f/8)). L_t is the cubic Lagrange basis on nodes 0..3, and half-way values round away from zero. For f = 0 the set is {0,256,0,0}. A sample x presented on the n-th edge after the strobe contributes h_f[t]·x to `beam_out` after edge n + I + 4 + t.
- R4: The products are exact, and `beam_out` is the full-precision 23-bit sum over all channels and taps. It does not overflow for any input.
- R5: With `wr_en` high, `wr_delay` = {I[8:3], f[2:0]} goes into the staging slot of channel `wr_ch`. A `wr_ch` of 6 or 7 changes nothing. A staged value has no effect on the beam until `apply`.
- R6: On the `apply` edge, every delay line and pipeline register is cleared. The sample present on that edge is discarded, and `beam_out` reads 0 immediately afterwards.
- R7: `beam_valid` goes low on the `apply` edge. It goes high after the edge that lies Imax + 8 cycles later, where Imax is the largest applied whole-sample delay. It then stays high until the next `apply`. It is low from reset until the first `apply`.
- R8: After reset, all staged and applied delays are zero (I = 0, f = 0), `beam_out` is 0 and `beam_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 48 | Six packed signed input samples |
| wr_en | input | 1 | Write strobe for one staging slot |
| wr_ch | input | 3 | Channel index of the write |
| wr_delay | input | 9 | Delay word, whole part over fraction |
| apply | input | 1 | Commit staged delays and clear the datapath |
| beam_out | output | 23 | Summed beam sample, signed |
| beam_valid | output | 1 | Beam holds only post-strobe data |

## Verification
The bench sends impulses through each channel in turn, over every fraction and out to the largest whole delay. A wrong coefficient table, a wrong tap order or an off-by-one tap select would put the impulse response at the wrong cycle or at the wrong amplitude. Before every strobe, and on the strobe edge itself, the bench drives random data. A design that failed to flush its delay lines would let that data leak into the first beams. Other checks target the staging bank: writes with no strobe that follows, and writes to channel indices 6 and 7. A design that applied writes at once, or that wrapped the index, would shift the impulse of an existing channel. Full-scale input patterns expose a sum that is too narrow. Finally, the bench checks the cycle on which `beam_valid` rises after each strobe; an early rise would flag beams that still hold cleared taps.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int FRAC_W      = 3;
    localparam int NTAP        = 4;
    localparam int COEF_W      = 10;
    localparam int NIB         = 4;
    localparam int PIPE_STAGES = 4;

    // Cubic Lagrange interpolator sets, scale 256, one row per eighth of a sample
    localparam logic signed [COEF_W-1:0] COEF_TAB [8][NTAP] = '{
        '{ 10'sd0,   10'sd256,  10'sd0,   10'sd0  },
        '{-10'sd9,   10'sd236,  10'sd34, -10'sd5  },
        '{-10'sd14,  10'sd210,  10'sd70, -10'sd10 },
        '{-10'sd16,  10'sd179,  10'sd107,-10'sd14 },
        '{-10'sd16,  10'sd144,  10'sd144,-10'sd16 },
        '{-10'sd14,  10'sd107,  10'sd179,-10'sd16 },
        '{-10'sd10,  10'sd70,   10'sd210,-10'sd14 },
        '{-10'sd5,   10'sd34,   10'sd236,-10'sd9  }
    };
endpackage

// File: rtl/bf_delay_line.sv
module bf_delay_line #(
    parameter int SMP_W = 8,
    parameter int INT_W = 6,
    parameter int NTAP  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clear,
    input  logic signed [SMP_W-1:0]          sample_in,
    input  logic        [INT_W-1:0]          int_dly,
    output logic        [NTAP-1:0][SMP_W-1:0] taps
);
    localparam int DEPTH = (1 << INT_W) + NTAP - 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic signed [SMP_W-1:0] sh [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < DEPTH; i++) sh[i] <= '0;
        end else begin
            sh[0] <= sample_in;
            for (int i = 1; i < DEPTH; i++) sh[i] <= sh[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            taps <= '0;
        end else begin
            for (int t = 0; t < NTAP; t++)
                taps[t] <= sh[IDX_W'(int_dly) + IDX_W'(t)];
        end
    end

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        !clear |=> sh[1] == $past(sh[0]));
endmodule

// File: rtl/bf_frac_fir.sv
module bf_frac_fir
    import bf_pkg::*;
#(
    parameter int SMP_W  = 8,
    parameter int CHAN_W = SMP_W + COEF_W + 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load,
    input  logic        [FRAC_W-1:0]          frac_new,
    input  logic        [NTAP-1:0][SMP_W-1:0] taps,
    output logic signed [CHAN_W-1:0]          chan_sum
);
    localparam int TAB_W  = COEF_W + NIB;
    localparam int PROD_W = SMP_W + COEF_W;
    localparam int NNIB   = SMP_W / NIB;

    logic signed [COEF_W-1:0] coef [NTAP];
    logic signed [TAB_W-1:0]  tab  [NTAP][1 << NIB];
    logic signed [PROD_W-1:0] prod_c [NTAP];
    logic signed [PROD_W-1:0] prod   [NTAP];
    logic        [FRAC_W-1:0] fsel;

    assign fsel = rst ? '0 : frac_new;

    function automatic logic signed [TAB_W-1:0] nib_mult(
        input logic signed [COEF_W-1:0] c, input logic [NIB-1:0] u);
        logic signed [TAB_W-1:0] acc;
        acc = '0;
        for (int b = 0; b < NIB; b++)
            if (u[b]) acc = acc + (TAB_W'(c) <<< b);
        return acc;
    endfunction

    // Table of nibble multiples, rebuilt by shift-add at each load
    always_ff @(posedge clk) begin
        if (rst || load) begin
            for (int t = 0; t < NTAP; t++) begin
                coef[t] <= COEF_TAB[fsel][t];
                for (int u = 0; u < (1 << NIB); u++)
                    tab[t][u] <= nib_mult(COEF_TAB[fsel][t], NIB'(u));
            end
        end
    end

    // Product = sum of nibble lookups, minus the sign weight of the top bit
    always_comb begin
        for (int t = 0; t < NTAP; t++) begin
            prod_c[t] = taps[t][SMP_W-1] ? -(PROD_W'(coef[t]) <<< SMP_W) : '0;
            for (int g = 0; g < NNIB; g++)
                prod_c[t] = prod_c[t] + (PROD_W'(tab[t][taps[t][g*NIB +: NIB]]) <<< (NIB*g));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            for (int t = 0; t < NTAP; t++) prod[t] <= '0;
            chan_sum <= '0;
        end else begin
            for (int t = 0; t < NTAP; t++) prod[t] <= prod_c[t];
            chan_sum <= CHAN_W'(prod[0]) + CHAN_W'(prod[1]) + CHAN_W'(prod[2]) + CHAN_W'(prod[3]);
        end
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_chk
        assert_lut_product_R4: assert property (@(posedge clk) disable iff (rst)
            !load |=> prod[t] == PROD_W'($signed($past(taps[t]))) * PROD_W'($past(coef[t])));
    end
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl
    import bf_pkg::*;
#(
    parameter int INT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply,
    input  logic [INT_W-1:0] max_int,
    output logic             beam_valid
);
    localparam int CNT_W    = INT_W + 2;
    localparam int FILL_CYC = PIPE_STAGES + NTAP;

    typedef enum logic [1:0] { S_IDLE, S_FILL, S_RUN } bf_state_t;

    bf_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            lim   <= '0;
        end else begin
            state <= state_n;
            if (apply) begin
                cnt <= '0;
                lim <= CNT_W'(max_int) + CNT_W'(FILL_CYC - 1);
            end else if (state == S_FILL) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (apply) state_n = S_FILL;
            S_FILL: if (apply) state_n = S_FILL;
                    else if (cnt == lim) state_n = S_RUN;
            S_RUN:  if (apply) state_n = S_FILL;
            default: state_n = S_IDLE;
        endcase
    end

    always_comb beam_valid = (state == S_RUN);

    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
        apply |=> !beam_valid);
    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (beam_valid && !apply) |=> beam_valid);
    assert_fill_low_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_FILL && cnt != lim && !apply) |=> !beam_valid);
endmodule

// File: rtl/bf_beamformer.sv
module bf_beamformer
    import bf_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int SMP_W  = 8,
    parameter int INT_W  = 6,
    parameter int CH_W   = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_CH*SMP_W-1:0]             smp_in,
    input  logic                                wr_en,
    input  logic [CH_W-1:0]                     wr_ch,
    input  logic [INT_W+FRAC_W-1:0]             wr_delay,
    input  logic                                apply,
    output logic signed [SMP_W+COEF_W+$clog2(NTAP)+$clog2(NUM_CH)-1:0] beam_out,
    output logic                                beam_valid
);
    localparam int DLY_W  = INT_W + FRAC_W;
    localparam int CHAN_W = SMP_W + COEF_W + $clog2(NTAP);
    localparam int BEAM_W = CHAN_W + $clog2(NUM_CH);

    logic [DLY_W-1:0]         staged     [NUM_CH];
    logic [INT_W-1:0]         active_int [NUM_CH];
    logic signed [CHAN_W-1:0] chan_sum   [NUM_CH];
    logic [INT_W-1:0]         staged_max;
    logic signed [BEAM_W-1:0] beam_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                staged[c]     <= '0;
                active_int[c] <= '0;
            end
        end else begin
            if (apply)
                for (int c = 0; c < NUM_CH; c++) active_int[c] <= staged[c][DLY_W-1:FRAC_W];
            if (wr_en && (int'(wr_ch) < NUM_CH))
                staged[wr_ch] <= wr_delay;
        end
    end

    always_comb begin
        staged_max = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (staged[c][DLY_W-1:FRAC_W] > staged_max) staged_max = staged[c][DLY_W-1:FRAC_W];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [NTAP-1:0][SMP_W-1:0] taps;

        bf_delay_line #(.SMP_W(SMP_W), .INT_W(INT_W), .NTAP(NTAP)) u_dly (
            .clk(clk), .rst(rst), .clear(apply),
            .sample_in(smp_in[g*SMP_W +: SMP_W]),
            .int_dly(active_int[g]), .taps(taps));

        bf_frac_fir #(.SMP_W(SMP_W), .CHAN_W(CHAN_W)) u_fir (
            .clk(clk), .rst(rst), .load(apply),
            .frac_new(staged[g][FRAC_W-1:0]),
            .taps(taps), .chan_sum(chan_sum[g]));
    end

    always_comb begin
        beam_c = '0;
        for (int c = 0; c < NUM_CH; c++) beam_c = beam_c + BEAM_W'(chan_sum[c]);
    end

    always_ff @(posedge clk) begin
        if (rst || apply) beam_out <= '0;
        else              beam_out <= beam_c;
    end

    bf_ctrl #(.INT_W(INT_W)) u_ctrl (
        .clk(clk), .rst(rst), .apply(apply),
        .max_int(staged_max), .beam_valid(beam_valid));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        apply |=> beam_out == '0);
endmodule

// File: tb/bf_beamformer_bench.sv
`timescale 1ns/1ps
module bf_beamformer_bench;
    localparam int NCH = 6;
    localparam int MAXK = 128;

    logic        clk = 1'b0;
    logic        rst, wr_en, apply;
    logic [2:0]  wr_ch;
    logic [8:0]  wr_delay;
    logic [47:0] smp_in;
    logic signed [22:0] beam_out;
    logic        beam_valid;

    int errors = 0;
    int checks = 0;
    int stim [NCH][MAXK];
    int aI [NCH], aF [NCH], sI [NCH], sF [NCH];

    bf_beamformer u_bf_beamformer (
        .clk(clk), .rst(rst), .smp_in(smp_in), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_delay(wr_delay), .apply(apply), .beam_out(beam_out), .beam_valid(beam_valid));

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int hcoef(input int f, input int t);
        real d, p;
        d = 1.0 + f / 8.0;
        p = 256.0;
        for (int j = 0; j < 4; j++)
            if (j != t) p = p * (d - j) / real'(t - j);
        return (p >= 0.0) ? int'($floor(p + 0.5)) : -int'($floor(-p + 0.5));
    endfunction

    function automatic longint exp_beam(input int k);
        longint s = 0;
        for (int c = 0; c < NCH; c++)
            for (int t = 0; t < 4; t++) begin
                int idx = k - aI[c] - 4 - t;
                if (idx >= 1) s += longint'(hcoef(aF[c], t)) * stim[c][idx];
            end
        return s;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_stim();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < MAXK; k++) stim[c][k] = 0;
    endtask

    task automatic wr_dly(input int c, input int i, input int f);
        wr_en = 1'b1;
        wr_ch = 3'(c);
        wr_delay = {6'(i), 3'(f)};
        step();
        wr_en = 1'b0;
        if (c < NCH) begin sI[c] = i; sF[c] = f; end
    endtask

    // vmode: 0 valid always low, 1 always high, 2 rule after apply
    task automatic run_acq(input int nsteps, input bit do_apply, input int vmode, input string req);
        int imax = 0;
        if (do_apply) begin
            repeat (4) begin
                for (int c = 0; c < NCH; c++) smp_in[c*8 +: 8] = 8'($urandom_range(255));
                step();
            end
            apply = 1'b1;
            step();
            apply = 1'b0;
            for (int c = 0; c < NCH; c++) begin aI[c] = sI[c]; aF[c] = sF[c]; end
            chk("R6", "beam on apply edge", beam_out, 0);
            chk("R7", "valid on apply edge", beam_valid, 0);
        end
        for (int c = 0; c < NCH; c++) if (aI[c] > imax) imax = aI[c];
        for (int k = 1; k <= nsteps; k++) begin
            for (int c = 0; c < NCH; c++) smp_in[c*8 +: 8] = 8'(stim[c][k]);
            step();
            chk(req, $sformatf("beam k=%0d", k), beam_out, exp_beam(k));
            chk("R7", $sformatf("valid k=%0d", k), beam_valid,
                (vmode == 0) ? 0 : (vmode == 1) ? 1 : ((k >= imax + 8) ? 1 : 0));
        end
        smp_in = '0;
    endtask

    task automatic t_reset();
        chk("R8", "beam after reset", beam_out, 0);
        chk("R8", "valid after reset", beam_valid, 0);
        clear_stim();
        stim[3][1] = 50;
        run_acq(12, 1'b0, 0, "R8");
    endtask

    task automatic t_each_channel();
        for (int c = 0; c < NCH; c++) wr_dly(c, 2 + 5 * c, (c + 3) % 8);
        for (int c = 0; c < NCH; c++) begin
            clear_stim();
            stim[c][1] = 100 - 30 * c;
            run_acq(43, 1'b1, 2, "R3");
        end
    endtask

    task automatic t_frac_sweep();
        for (int c = 0; c < NCH; c++) wr_dly(c, 0, 0);
        for (int f = 0; f < 8; f++) begin
            wr_dly(1, 1, f);
            clear_stim();
            stim[1][1] = -77;
            stim[1][2] = 45;
            run_acq(20, 1'b1, 2, "R3");
        end
    endtask

    task automatic t_max_delay();
        for (int c = 0; c < NCH; c++) wr_dly(c, 0, 2);
        wr_dly(0, 63, 7);
        wr_dly(5, 63, 0);
        clear_stim();
        stim[0][1] = -128;
        stim[5][3] = 127;
        stim[2][2] = 60;
        run_acq(80, 1'b1, 2, "R2");
    endtask

    task automatic t_full_scale();
        for (int c = 0; c < NCH; c++) wr_dly(c, 0, 4);
        clear_stim();
        for (int k = 1; k <= 20; k++)
            for (int c = 0; c < NCH; c++) stim[c][k] = -128;
        for (int k = 21; k <= 40; k++)
            for (int c = 0; c < NCH; c++) stim[c][k] = (((k / 2) % 2) == 0) ? 127 : -128;
        run_acq(46, 1'b1, 2, "R4");
    endtask

    task automatic t_staged();
        for (int c = 0; c < NCH; c++) wr_dly(c, 4, 0);
        clear_stim();
        stim[2][1] = 90;
        run_acq(20, 1'b1, 2, "R5");
        wr_dly(2, 10, 3);
        wr_dly(6, 30, 5);
        wr_dly(7, 40, 1);
        run_acq(20, 1'b0, 1, "R5");
        clear_stim();
        for (int c = 0; c < NCH; c++) stim[c][1] = 10 * (c + 1);
        run_acq(30, 1'b1, 2, "R5");
    endtask

    task automatic t_random();
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < NCH; c++) wr_dly(c, $urandom_range(20), $urandom_range(7));
            clear_stim();
            for (int k = 1; k <= 60; k++)
                for (int c = 0; c < NCH; c++) stim[c][k] = int'($urandom_range(255)) - 128;
            run_acq(60, 1'b1, 2, "R1");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin aI[c] = 0; aF[c] = 0; sI[c] = 0; sF[c] = 0; end
        rst = 1'b1; wr_en = 1'b0; apply = 1'b0; wr_ch = '0; wr_delay = '0; smp_in = '0;
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_each_channel();
        t_frac_sweep();
        t_max_delay();
        t_full_scale();
        t_staged();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule